// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block holds a bank of hardware semaphores that several processors share to coordinate access to common resources. Every processor has its own simple register port made of byte address, write data, write enable, read enable and read data. Each port can make one access per cycle, and all ports work at the same time. Each semaphore is a word register that stores a 4-bit owner ID, and an owner ID of zero means the semaphore is free.

To take a semaphore, a processor writes its own nonzero ID to the semaphore register and then reads the register back. The processor holds the semaphore only if the low nibble it reads back equals its own ID. To give the semaphore up, the processor writes zero to it.

A control word stores the protocol-select bit. A sticky event register records which semaphores have been released. Writing the clear key to a clear-all location empties the event register in one access. All state resets synchronously when the active-high reset is high.

Top module: `hsem_bank`

## Requirements
- R1: While reset is high and after it falls, every semaphore reads as 0, the control word reads as 0 and the event register reads as 0.
- R2: A write whose low nibble is nonzero, made to a free semaphore, stores that nibble as owner. Reads of a semaphore return the owner in bits [3:0], and bits [31:4] read as zero.
- R3: A write with a nonzero low nibble to a semaphore that already has an owner changes nothing, so the existing owner is kept.
- R4: A write whose low nibble is zero frees the semaphore, whichever port makes it. Bits [31:4] of the write data are ignored.
- R5: When more than one port writes the same semaphore in one cycle, only the write from the lowest-numbered port takes effect, and the other writes are discarded. The same lowest-port rule applies to the control word.
- R6: Offset 0x00 is the control word. Bit 0 stores write-data bit 0 and reads back in bit 0, the other bits read as zero, and the stored value has no effect on the semaphores. The value 0 selects the write-ID-then-read-back scheme.
- R7: Offset 0x90 is the clear-all location. A write there whose data bits [15:0] are all ones clears every event bit, and any other write value has no effect. The location reads as zero. A release in the same cycle as a clear-all leaves that release's event bit set.
- R8: Offset 0x94 reads the event register. Bit i becomes 1 when a held semaphore i is freed. Freeing a semaphore that is already free sets nothing.
- R9: Reads of unmapped offsets return zero, and writes to them change no state. Unmapped offsets include 0x04, every offset past the last semaphore other than 0x90 and 0x94, and any offset with bits [1:0] nonzero.
- R10: The read data of a port appears in the cycle after the cycle in which read enable is high. It shows the state as it was before any write made in the same cycle as the read. After a cycle with read enable low, the read data is zero.
- R11: Semaphore i sits at byte offset 0x08 + 4*i, for i from 0 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | NUM_PORTS*ADDR_W | Byte address, one field per port, port 0 in the low bits |
| bus_wdata | input | NUM_PORTS*32 | Write data, one word per port |
| bus_we | input | NUM_PORTS | Write enable per port |
| bus_re | input | NUM_PORTS | Read enable per port |
| bus_rdata | output | NUM_PORTS*32 | Registered read data per port |

## Verification
Two kinds of event can happen in the same cycle. The first is a collision, where two ports claim or release the same semaphore at once. The second is a release that lands in the same cycle as a clear-all.

Directed cases force each of these: a claim against a claim, a release against a claim, and a release against a clear-all made from the other port. In addition, a seeded random run aims most semaphore accesses at four slots so that collisions happen often. A bench model applies the lowest-port rule and the rule that a new release survives a clear-all, and every read-back is compared with that model.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned OWNER_W    = 4;
    localparam int unsigned SLOT_IDX_W = 8;
    localparam int unsigned KEY_W      = 16;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_SLOT0  = 8'h08;
    localparam logic [7:0] OFS_CLRALL = 8'h90;
    localparam logic [7:0] OFS_EVENTS = 8'h94;

    localparam logic [KEY_W-1:0] CLRALL_KEY = '1;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_SLOT,
        RK_CLRALL,
        RK_EVENTS
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [SLOT_IDX_W-1:0] slot;
    } reg_sel_t;

    typedef struct packed {
        logic               hit;
        logic [OWNER_W-1:0] id;
    } claim_req_t;

    function automatic logic [WORD_W-1:0] owner_word(input logic [OWNER_W-1:0] id);
        return {{(WORD_W-OWNER_W){1'b0}}, id};
    endfunction
endpackage

// File: rtl/hsem_decode.sv
module hsem_decode
    import hsem_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_SLOTS = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned SPAN = 4 * NUM_SLOTS;

    logic [ADDR_W-1:0] rel;

    always_comb begin
        sel.kind = RK_NONE;
        sel.slot = '0;
        rel      = addr - ADDR_W'(OFS_SLOT0);
        if (addr[1:0] == 2'b00) begin
            if (addr == ADDR_W'(OFS_CTRL)) begin
                sel.kind = RK_CTRL;
            end else if (addr == ADDR_W'(OFS_CLRALL)) begin
                sel.kind = RK_CLRALL;
            end else if (addr == ADDR_W'(OFS_EVENTS)) begin
                sel.kind = RK_EVENTS;
            end else if (addr >= ADDR_W'(OFS_SLOT0) && rel < ADDR_W'(SPAN)) begin
                sel.kind = RK_SLOT;
                sel.slot = SLOT_IDX_W'(rel >> 2);
            end
        end
    end

    // R11: a slot hit only ever names an existing semaphore
    always_comb begin
        if (sel.kind == RK_SLOT) begin
            assert (sel.slot < SLOT_IDX_W'(NUM_SLOTS))
                else $error("slot index out of range");
        end
    end
endmodule

// File: rtl/hsem_slot.sv
module hsem_slot
    import hsem_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_PORTS-1:0]         wr_hit,
    input  logic [NUM_PORTS*OWNER_W-1:0] wr_id,
    output logic [OWNER_W-1:0]           owner,
    output logic                         released
);
    timeunit 1ns;
    timeprecision 1ps;

    claim_req_t         win;
    logic [OWNER_W-1:0] owner_q;

    // lowest port index is visited last and therefore wins
    always_comb begin
        win = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (wr_hit[p]) begin
                win.hit = 1'b1;
                win.id  = wr_id[p*OWNER_W +: OWNER_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= '0;
        end else if (win.hit) begin
            if (win.id == '0) begin
                owner_q <= '0;
            end else if (owner_q == '0) begin
                owner_q <= win.id;
            end
        end
    end

    assign owner    = owner_q;
    assign released = win.hit && (win.id == '0) && (owner_q != '0);

    p_claim_free_r2: assert property (@(posedge clk) disable iff (rst)
        (owner_q == '0 && win.hit && win.id != '0) |=> owner_q == $past(win.id));

    p_held_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (owner_q != '0 && win.hit && win.id != '0) |=> $stable(owner_q));

    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (win.hit && win.id == '0) |=> owner_q == '0);

    p_no_write_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !win.hit |=> $stable(owner_q));
endmodule

// File: rtl/hsem_glob.sv
module hsem_glob
    import hsem_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned NUM_SLOTS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] ctrl_hit,
    input  logic [NUM_PORTS-1:0] ctrl_bit,
    input  logic [NUM_PORTS-1:0] clr_hit,
    input  logic [NUM_SLOTS-1:0] rel_evt,
    output logic                 ctrl,
    output logic [NUM_SLOTS-1:0] events
);
    timeunit 1ns;
    timeprecision 1ps;

    logic                 ctrl_q;
    logic                 ctrl_nx;
    logic                 ctrl_we;
    logic [NUM_SLOTS-1:0] events_q;

    always_comb begin
        ctrl_we = 1'b0;
        ctrl_nx = ctrl_q;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (ctrl_hit[p]) begin
                ctrl_we = 1'b1;
                ctrl_nx = ctrl_bit[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= 1'b0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_nx;
        end
    end

    // a fresh release outranks a clear-all in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            events_q <= '0;
        end else if (|clr_hit) begin
            events_q <= rel_evt;
        end else begin
            events_q <= events_q | rel_evt;
        end
    end

    assign ctrl   = ctrl_q;
    assign events = events_q;

    p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(|ctrl_hit) |=> $stable(ctrl_q));

    p_clear_all_r7: assert property (@(posedge clk) disable iff (rst)
        (|clr_hit && !(|rel_evt)) |=> events_q == '0);

    p_event_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (|rel_evt) |=> ((events_q & $past(rel_evt)) == $past(rel_evt)));

    p_event_keep_r8: assert property (@(posedge clk) disable iff (rst)
        !(|clr_hit) |=> ((events_q & $past(events_q)) == $past(events_q)));
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
    import hsem_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS*ADDR_W-1:0] bus_addr,
    input  logic [NUM_PORTS*32-1:0]     bus_wdata,
    input  logic [NUM_PORTS-1:0]        bus_we,
    input  logic [NUM_PORTS-1:0]        bus_re,
    output logic [NUM_PORTS*32-1:0]     bus_rdata
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned SIDX_W = $clog2(NUM_SLOTS);

    reg_sel_t                     sel [NUM_PORTS];
    logic [NUM_PORTS*OWNER_W-1:0] all_ids;
    logic [NUM_PORTS-1:0]         ctrl_hit;
    logic [NUM_PORTS-1:0]         ctrl_bit;
    logic [NUM_PORTS-1:0]         clr_hit;
    logic [OWNER_W-1:0]           owner [NUM_SLOTS];
    logic [NUM_SLOTS-1:0]         rel_evt;
    logic                         ctrl_q;
    logic [NUM_SLOTS-1:0]         events_q;
    logic [WORD_W-1:0]            rword [NUM_PORTS];
    logic [WORD_W-1:0]            rdata_q [NUM_PORTS];
    logic                         unused_wd;

    assign unused_wd = ^bus_wdata;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        hsem_decode #(
            .ADDR_W   (ADDR_W),
            .NUM_SLOTS(NUM_SLOTS)
        ) u_dec (
            .addr(bus_addr[p*ADDR_W +: ADDR_W]),
            .sel (sel[p])
        );

        assign all_ids[p*OWNER_W +: OWNER_W] = bus_wdata[p*WORD_W +: OWNER_W];
        assign ctrl_hit[p] = bus_we[p] && (sel[p].kind == RK_CTRL);
        assign ctrl_bit[p] = bus_wdata[p*WORD_W];
        assign clr_hit[p]  = bus_we[p] && (sel[p].kind == RK_CLRALL)
                          && (bus_wdata[p*WORD_W +: KEY_W] == CLRALL_KEY);

        always_comb begin
            case (sel[p].kind)
                RK_CTRL:   rword[p] = WORD_W'(ctrl_q);
                RK_SLOT:   rword[p] = owner_word(owner[sel[p].slot[SIDX_W-1:0]]);
                RK_EVENTS: rword[p] = WORD_W'(events_q);
                default:   rword[p] = '0;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                rdata_q[p] <= '0;
            end else if (bus_re[p]) begin
                rdata_q[p] <= rword[p];
            end else begin
                rdata_q[p] <= '0;
            end
        end

        assign bus_rdata[p*WORD_W +: WORD_W] = rdata_q[p];

        p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
            (bus_re[p] && sel[p].kind == RK_NONE) |=> bus_rdata[p*WORD_W +: WORD_W] == '0);

        p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
            !bus_re[p] |=> bus_rdata[p*WORD_W +: WORD_W] == '0);

        p_slot_high_zero_r2: assert property (@(posedge clk) disable iff (rst)
            (bus_re[p] && sel[p].kind == RK_SLOT)
            |=> bus_rdata[p*WORD_W + OWNER_W +: WORD_W - OWNER_W] == '0);
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [NUM_PORTS-1:0] hit;

        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
            assign hit[p] = bus_we[p] && (sel[p].kind == RK_SLOT)
                         && (sel[p].slot == SLOT_IDX_W'(s));
        end

        hsem_slot #(
            .NUM_PORTS(NUM_PORTS)
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (hit),
            .wr_id   (all_ids),
            .owner   (owner[s]),
            .released(rel_evt[s])
        );
    end

    hsem_glob #(
        .NUM_PORTS(NUM_PORTS),
        .NUM_SLOTS(NUM_SLOTS)
    ) u_glob (
        .clk     (clk),
        .rst     (rst),
        .ctrl_hit(ctrl_hit),
        .ctrl_bit(ctrl_bit),
        .clr_hit (clr_hit),
        .rel_evt (rel_evt),
        .ctrl    (ctrl_q),
        .events  (events_q)
    );
endmodule

// File: tb/hsem_bank_tb_top.sv
module hsem_bank_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NP = 2;
    localparam int NS = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        t_addr [NP];
    logic [31:0]       t_wd   [NP];
    logic              t_we   [NP];
    logic              t_re   [NP];
    logic [NP*8-1:0]   bus_addr;
    logic [NP*32-1:0]  bus_wdata;
    logic [NP-1:0]     bus_we;
    logic [NP-1:0]     bus_re;
    logic [NP*32-1:0]  bus_rdata;

    logic [3:0]  m_own [NS];
    logic        m_ctrl;
    logic [31:0] m_evt;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            bus_addr[p*8 +: 8]   = t_addr[p];
            bus_wdata[p*32 +: 32] = t_wd[p];
            bus_we[p]            = t_we[p];
            bus_re[p]            = t_re[p];
        end
    end

    hsem_bank #(.NUM_PORTS(NP), .NUM_SLOTS(NS), .ADDR_W(8)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .bus_rdata(bus_rdata)
    );

    function automatic int slot_of(input logic [7:0] a);
        if (a[1:0] != 2'b00 || a < 8'h08 || a >= 8'h88) return -1;
        return int'((a - 8'h08) >> 2);
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int s;
        s = slot_of(a);
        if (s >= 0) return {28'h0, m_own[s]};
        if (a == 8'h00) return {31'h0, m_ctrl};
        if (a == 8'h94) return m_evt;
        return 32'h0;
    endfunction

    function automatic string kind_tag(input logic [7:0] a, input logic re);
        if (!re) return "R10";
        if (slot_of(a) >= 0) return "R2";
        if (a == 8'h00) return "R6";
        if (a == 8'h94) return "R8";
        if (a == 8'h90) return "R7";
        return "R9";
    endfunction

    task automatic model_apply();
        bit [NS-1:0] done = '0;
        logic [31:0] rel = '0;
        bit ctrl_done = 0;
        bit clr = 0;
        for (int p = 0; p < NP; p++) begin
            if (t_we[p]) begin
                int s;
                s = slot_of(t_addr[p]);
                if (s >= 0 && !done[s]) begin
                    done[s] = 1'b1;
                    if (t_wd[p][3:0] == 4'h0) begin
                        if (m_own[s] != 4'h0) rel[s] = 1'b1;
                        m_own[s] = 4'h0;
                    end else if (m_own[s] == 4'h0) begin
                        m_own[s] = t_wd[p][3:0];
                    end
                end
                if (t_addr[p] == 8'h00 && !ctrl_done) begin
                    ctrl_done = 1;
                    m_ctrl = t_wd[p][0];
                end
                if (t_addr[p] == 8'h90 && t_wd[p][15:0] == 16'hFFFF) clr = 1;
            end
        end
        m_evt = (clr ? 32'h0 : m_evt) | rel;
    endtask

    task automatic idle_all();
        for (int p = 0; p < NP; p++) begin
            t_we[p] = 1'b0; t_re[p] = 1'b0; t_addr[p] = 8'h00; t_wd[p] = 32'h0;
        end
    endtask

    task automatic put(input int p, input logic we, input logic re,
                       input logic [7:0] a, input logic [31:0] d);
        t_we[p] = we; t_re[p] = re; t_addr[p] = a; t_wd[p] = d;
    endtask

    // apply the current port ops for one cycle and check read data
    task automatic tick(input string tag);
        logic [31:0] er [NP];
        string kt [NP];
        for (int p = 0; p < NP; p++) begin
            er[p] = t_re[p] ? model_read(t_addr[p]) : 32'h0;
            kt[p] = kind_tag(t_addr[p], t_re[p]);
        end
        model_apply();
        @(posedge clk);
        #1;
        for (int p = 0; p < NP; p++) begin
            n_checks++;
            if (bus_rdata[p*32 +: 32] !== er[p]) begin
                n_fail++;
                $display("FAIL %s/%s port %0d addr %h: actual %h expected %h",
                         tag, kt[p], p, t_addr[p], bus_rdata[p*32 +: 32], er[p]);
            end
        end
        @(negedge clk);
        idle_all();
    endtask

    function automatic logic [7:0] slot_addr(input int s);
        return 8'(8 + 4 * s);
    endfunction

    function automatic logic [7:0] rand_addr();
        int r;
        logic [7:0] odd [7];
        odd = '{8'h04, 8'h88, 8'h8C, 8'h98, 8'hFC, 8'h0A, 8'h0D};
        r = $urandom_range(0, 19);
        if (r < 8) return slot_addr($urandom_range(0, 3));
        if (r < 11) return slot_addr($urandom_range(0, NS - 1));
        if (r < 13) return 8'h00;
        if (r < 15) return 8'h90;
        if (r < 17) return 8'h94;
        return odd[$urandom_range(0, 6)];
    endfunction

    function automatic logic [31:0] rand_data(input logic [7:0] a);
        logic [31:0] d;
        d = $urandom();
        if (a == 8'h90 && $urandom_range(0, 1) == 1) d[15:0] = 16'hFFFF;
        if (slot_of(a) >= 0 && $urandom_range(0, 2) == 0) d[3:0] = 4'h0;
        return d;
    endfunction

    initial begin
        void'($urandom(32'h1F2E3D4C));
        idle_all();
        for (int s = 0; s < NS; s++) m_own[s] = 4'h0;
        m_ctrl = 1'b0;
        m_evt  = 32'h0;
        // dirty the bus during reset: nothing must stick
        put(0, 1'b1, 1'b1, slot_addr(3), 32'h5);
        put(1, 1'b1, 1'b0, 8'h00, 32'h1);
        repeat (4) @(posedge clk);
        #1;
        n_checks++;
        if (bus_rdata !== '0) begin
            n_fail++;
            $display("FAIL R1 read data during reset: actual %h expected 0", bus_rdata);
        end
        @(negedge clk);
        rst = 1'b0;
        idle_all();

        // R1: everything empty after reset
        for (int s = 0; s < NS; s++) begin
            put(0, 1'b0, 1'b1, slot_addr(s), 32'h0);
            put(1, 1'b0, 1'b1, (s % 2 == 0) ? 8'h00 : 8'h94, 32'h0);
            tick("R1");
        end

        // R11: distinct owners across the whole map, read back from the other port
        for (int s = 0; s < NS; s++) begin
            put(1, 1'b1, 1'b0, slot_addr(s), 32'hABCD_0000 | 32'((s % 15) + 1));
            tick("R11");
        end
        for (int s = 0; s < NS; s++) begin
            put(0, 1'b0, 1'b1, slot_addr(s), 32'h0);
            tick("R11");
        end

        // R4: release all with nonzero upper bits, events all set
        for (int s = 0; s < NS; s++) begin
            put(0, 1'b1, 1'b0, slot_addr(s), 32'hFFFF_FFF0);
            tick("R4");
        end
        put(0, 1'b0, 1'b1, 8'h94, 32'h0); tick("R8");
        put(0, 1'b0, 1'b1, slot_addr(9), 32'h0); tick("R4");

        // R7: wrong key ignored, right key clears, location reads zero
        put(1, 1'b1, 1'b0, 8'h90, 32'h0000_FFFE); tick("R7");
        put(0, 1'b0, 1'b1, 8'h94, 32'h0); put(1, 1'b0, 1'b1, 8'h90, 32'h0); tick("R7");
        put(1, 1'b1, 1'b0, 8'h90, 32'h0000_FFFF); tick("R7");
        put(0, 1'b0, 1'b1, 8'h94, 32'h0); tick("R7");

        // R8: releasing a free slot sets no event
        put(0, 1'b1, 1'b0, slot_addr(2), 32'h0); tick("R8");
        put(0, 1'b0, 1'b1, 8'h94, 32'h0); tick("R8");

        // R3: held slot keeps its owner
        put(0, 1'b1, 1'b0, slot_addr(5), 32'h3); tick("R2");
        put(1, 1'b1, 1'b0, slot_addr(5), 32'h9); tick("R3");
        put(1, 1'b0, 1'b1, slot_addr(5), 32'h0); tick("R3");

        // R5: same-cycle claims, port 0 wins
        put(0, 1'b1, 1'b0, slot_addr(7), 32'h2);
        put(1, 1'b1, 1'b0, slot_addr(7), 32'h6); tick("R5");
        put(1, 1'b0, 1'b1, slot_addr(7), 32'h0); tick("R5");
        // R5: release on port 0 beats claim on port 1
        put(0, 1'b1, 1'b0, slot_addr(7), 32'h0);
        put(1, 1'b1, 1'b0, slot_addr(7), 32'h6); tick("R5");
        put(1, 1'b0, 1'b1, slot_addr(7), 32'h0); tick("R5");
        // R5: claim on port 0 against release on port 1 of a free slot
        put(0, 1'b1, 1'b0, slot_addr(8), 32'hC);
        put(1, 1'b1, 1'b0, slot_addr(8), 32'h0); tick("R5");
        put(0, 1'b0, 1'b1, slot_addr(8), 32'h0); tick("R5");

        // R7: release and clear-all in one cycle, release bit survives
        put(1, 1'b1, 1'b0, 8'h90, 32'hFFFF); tick("R7");
        put(0, 1'b1, 1'b0, slot_addr(5), 32'h0);
        put(1, 1'b1, 1'b0, 8'h90, 32'hFFFF); tick("R7");
        put(0, 1'b0, 1'b1, 8'h94, 32'h0); tick("R7");

        // R10: read and write in one cycle returns the prior state
        put(0, 1'b1, 1'b1, slot_addr(12), 32'hA); tick("R10");
        put(0, 1'b0, 1'b1, slot_addr(12), 32'h0); tick("R10");
        tick("R10");

        // R6: control bit stores bit 0 only and leaves semaphores alone
        put(0, 1'b1, 1'b0, 8'h00, 32'hFFFF_FFFF); tick("R6");
        put(1, 1'b0, 1'b1, 8'h00, 32'h0); put(0, 1'b0, 1'b1, slot_addr(12), 32'h0); tick("R6");
        put(0, 1'b1, 1'b0, 8'h00, 32'h0);
        put(1, 1'b1, 1'b0, 8'h00, 32'h1); tick("R5");
        put(1, 1'b0, 1'b1, 8'h00, 32'h0); tick("R6");

        // R9: unmapped writes touch nothing, reads give zero
        put(0, 1'b1, 1'b0, 8'h09, 32'h0); put(1, 1'b1, 1'b0, 8'h04, 32'h7); tick("R9");
        put(0, 1'b1, 1'b0, 8'h88, 32'h5); put(1, 1'b1, 1'b0, 8'h0A, 32'h0); tick("R9");
        put(0, 1'b0, 1'b1, 8'h04, 32'h0); put(1, 1'b0, 1'b1, 8'h88, 32'h0); tick("R9");
        put(0, 1'b0, 1'b1, slot_addr(0), 32'h0); put(1, 1'b0, 1'b1, slot_addr(12), 32'h0); tick("R9");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < NP; p++) begin
                logic [7:0] a;
                a = rand_addr();
                put(p, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), a, rand_data(a));
            end
            tick("R5");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule